// File: doc/BRIEF.md
# Auto-Reload PWM Timer

An 8-bit up-counter advances on ticks from a power-of-two clock divider or on rising edges seen on an external event pin. When it passes 0xFF it reloads from a programmable reload value. This sets a flag and can raise an interrupt. The reload value therefore sets the period. A higher reload gives a faster PWM with fewer usable duty steps. A reload of 0 gives the full 256-step resolution.

Four PWM channels compare the counter against their own compare value. Each channel has an enable bit and a polarity bit. Software writes a duty value into a holding register. That value becomes the active compare value only when the counter reloads, so a running period is never cut short. Two capture inputs copy the counter value on a selectable edge. Each capture input sets its own flag and can raise its own interrupt, so the captures can also serve as edge-triggered interrupt inputs.

Software reaches the block through a byte-wide register bus. Writes take effect on the clock edge. Reads are combinational from the address.

Register map, with addresses in hex:

| Address | Name | Bit layout |
|---|---|---|
| 0 | control | bit0 run, bits3:1 divider select s, bit4 external clock, bit5 overflow interrupt enable, bit6 capture 0 falling edge, bit7 capture 1 falling edge |
| 1 | reload | reload value |
| 2 | counter | counter value |
| 3 | output config | bits3:0 enables, bits7:4 polarities |
| 4 to 7 | duty | duty holding registers for channels 0 to 3 |
| 8, 9 | capture | captured values for capture inputs 0 and 1 |
| A | status | bit0 overflow flag, bit1 capture 0 flag, bit2 capture 1 flag |
| B | capture interrupt enable | bit0 and bit1 for capture inputs 0 and 1 |

Top module: `arpwm_timer`

## Requirements
- R1: After reset, every register reads 0, all PWM outputs are low and all interrupt outputs are low.
- R2: With run=1 and the external clock bit clear, the counter advances by one every 2^s clock cycles. Here s is the divider select in control bits 3:1, so the divide ratio runs from 1 to 128. With run=0 the counter holds.
- R3: A tick with the counter at 0xFF loads the reload value (address 1) and sets the overflow flag (status bit0). irq_ovf_o equals that flag ANDed with the overflow interrupt enable (control bit5). Writing a 1 to status bit0 clears the flag.
- R4: A write to a duty register (addresses 4 to 7) does not change that channel's output until the next reload. From the reload on, the new value is in effect.
- R5: For an enabled channel with polarity 0, the output is 1 when the counter is at or above the active compare value, and 0 otherwise. A compare value of 0xFF gives a constant 0. A compare value at or below the reload value gives a constant 1. A channel whose enable bit (address 3, bits3:0) is 0 outputs 0.
- R6: A polarity bit of 1 (address 3, bits7:4) inverts an enabled channel's waveform.
- R7: With the external clock bit set (control bit4) and run=1, each rising edge on ext_clk_i advances the counter by one, including reloads and the overflow flag.
- R8: The selected edge on cap_i[k] copies the counter into capture register k (address 8+k) and sets status bit k+1. Control bit 6+k selects the edge: 0 for rising, 1 for falling. The opposite edge changes nothing. irq_cap_o[k] equals that flag ANDed with enable bit k at address B. Writing a 1 to the flag bit clears it.
- R9: A write to address 2 loads the counter, and a read of address 2 returns its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_clk_i | input | 1 | External event input, synchronised inside the block |
| cap_i | input | 2 | Capture inputs, synchronised inside the block |
| pwm_o | output | 4 | PWM outputs |
| irq_ovf_o | output | 1 | Overflow (time-base) interrupt |
| irq_cap_o | output | 2 | Capture interrupts |

## Verification
The assertions assume that the inputs are synchronous to clk and that only one register is written per cycle. They also assume that ext_clk_i and cap_i hold each level for several clock cycles, so that the synchroniser sees every edge. The stimulus drives all inputs on the falling clock edge. It holds each external and capture level for at least four cycles. It writes duty values only while the counter is far from 0xFF, so a duty write never lands on the same cycle as a reload.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;
    localparam int CW     = 8;   // counter width
    localparam int NCH    = 4;   // PWM channels
    localparam int NCAP   = 2;   // capture inputs
    localparam int PRE_W  = 7;   // divider stages
    localparam int SEL_W  = 3;   // divider select width
    localparam int AW     = 4;   // bus address width

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        logic             cap1_fall;
        logic             cap0_fall;
        logic             ovf_ie;
        logic             ext_sel;
        logic [SEL_W-1:0] div_sel;
        logic             run;
    } ctrl_t;

    typedef enum logic [AW-1:0] {
        A_CTRL   = 4'h0,
        A_RELOAD = 4'h1,
        A_COUNT  = 4'h2,
        A_OUTCFG = 4'h3,
        A_DUTY0  = 4'h4,
        A_DUTY1  = 4'h5,
        A_DUTY2  = 4'h6,
        A_DUTY3  = 4'h7,
        A_CAP0   = 4'h8,
        A_CAP1   = 4'h9,
        A_STAT   = 4'hA,
        A_CAPIE  = 4'hB
    } addr_e;

    // Raw PWM level before polarity: 0xFF compare means permanently low.
    function automatic logic pwm_level(input cnt_t c, input cnt_t cmp);
        return (cmp != '1) && (c >= cmp);
    endfunction
endpackage

// File: rtl/arpwm_sync_edge.sv
module arpwm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~prev_q;
    assign fall = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/arpwm_prescaler.sv
module arpwm_prescaler
    import arpwm_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             ext_sel,
    input  logic             ext_rise,
    output logic             tick
);
    logic [W-1:0] pre_q;
    logic [W-1:0] mask;

    always_comb mask = (W'(1) << div_sel) - W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else             pre_q <= pre_q + W'(1);
    end

    assign tick = run && (ext_sel ? ext_rise : ((pre_q & mask) == mask));
endmodule

// File: rtl/arpwm_channel.sv
module arpwm_channel
    import arpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t duty,
    input  cnt_t cnt,
    input  logic en,
    input  logic pol,
    output cnt_t cmp,
    output logic pwm
);
    cnt_t cmp_q;

    always_ff @(posedge clk) begin
        if (rst)       cmp_q <= '0;
        else if (load) cmp_q <= duty;
    end

    assign cmp = cmp_q;
    assign pwm = en & (pwm_level(cnt, cmp_q) ^ pol);
endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer
    import arpwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [CW-1:0]   bus_wdata,
    output logic [CW-1:0]   bus_rdata,
    input  logic            ext_clk_i,
    input  logic [NCAP-1:0] cap_i,
    output logic [NCH-1:0]  pwm_o,
    output logic            irq_ovf_o,
    output logic [NCAP-1:0] irq_cap_o
);
    ctrl_t                  ctrl_q;
    cnt_t                   reload_q;
    cnt_t                   cnt_q;
    logic [NCH-1:0]         out_en;
    logic [NCH-1:0]         out_pol;
    logic [NCH-1:0][CW-1:0] duty_q;
    logic [NCH-1:0][CW-1:0] cmp_w;
    logic [NCAP-1:0][CW-1:0] cap_q;
    logic                   ovf_flag;
    logic [NCAP-1:0]        cap_flag;
    logic [NCAP-1:0]        cap_ie;
    logic [NCAP-1:0]        cap_fall_sel;
    logic [NCAP-1:0]        cap_rise;
    logic [NCAP-1:0]        cap_fallev;
    logic [NCAP-1:0]        cap_ev;
    logic                   ext_rise;
    logic                   ext_fall;
    logic                   tick;
    logic                   wrap;
    logic                   cnt_wr;
    logic                   stat_wr;

    assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
    assign stat_wr = bus_wr && (bus_addr == A_STAT);

    // control-side registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            out_en   <= '0;
            out_pol  <= '0;
            cap_ie   <= '0;
        end else if (bus_wr) begin
            case (addr_e'(bus_addr))
                A_CTRL:   ctrl_q   <= ctrl_t'(bus_wdata);
                A_RELOAD: reload_q <= bus_wdata;
                A_OUTCFG: {out_pol, out_en} <= bus_wdata;
                A_CAPIE:  cap_ie   <= bus_wdata[NCAP-1:0];
                default: ;
            endcase
        end
    end

    arpwm_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk_i), .rise(ext_rise), .fall(ext_fall)
    );

    arpwm_prescaler u_pre (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .div_sel(ctrl_q.div_sel),
        .ext_sel(ctrl_q.ext_sel), .ext_rise(ext_rise), .tick(tick)
    );

    // reload counter
    assign wrap = tick && (cnt_q == '1) && !cnt_wr;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (cnt_wr) cnt_q <= bus_wdata;
        else if (tick)   cnt_q <= (cnt_q == '1) ? reload_q : cnt_q + cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                        ovf_flag <= 1'b0;
        else if (wrap)                  ovf_flag <= 1'b1;
        else if (stat_wr && bus_wdata[0]) ovf_flag <= 1'b0;
    end

    assign irq_ovf_o = ovf_flag & ctrl_q.ovf_ie;

    // PWM channels
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) duty_q[i] <= '0;
            else if (bus_wr && (bus_addr == AW'(A_DUTY0) + AW'(i))) duty_q[i] <= bus_wdata;
        end

        arpwm_channel u_ch (
            .clk(clk), .rst(rst), .load(wrap), .duty(duty_q[i]), .cnt(cnt_q),
            .en(out_en[i]), .pol(out_pol[i]), .cmp(cmp_w[i]), .pwm(pwm_o[i])
        );
    end

    // captures
    assign cap_fall_sel = {ctrl_q.cap1_fall, ctrl_q.cap0_fall};

    for (genvar k = 0; k < NCAP; k++) begin : g_cap
        arpwm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .din(cap_i[k]), .rise(cap_rise[k]), .fall(cap_fallev[k])
        );

        assign cap_ev[k] = cap_fall_sel[k] ? cap_fallev[k] : cap_rise[k];

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q[k]    <= '0;
                cap_flag[k] <= 1'b0;
            end else if (cap_ev[k]) begin
                cap_q[k]    <= cnt_q;
                cap_flag[k] <= 1'b1;
            end else if (stat_wr && bus_wdata[k+1]) begin
                cap_flag[k] <= 1'b0;
            end
        end
    end

    assign irq_cap_o = cap_flag & cap_ie;

    // read mux
    always_comb begin
        case (addr_e'(bus_addr))
            A_CTRL:   bus_rdata = ctrl_q;
            A_RELOAD: bus_rdata = reload_q;
            A_COUNT:  bus_rdata = cnt_q;
            A_OUTCFG: bus_rdata = {out_pol, out_en};
            A_DUTY0:  bus_rdata = duty_q[0];
            A_DUTY1:  bus_rdata = duty_q[1];
            A_DUTY2:  bus_rdata = duty_q[2];
            A_DUTY3:  bus_rdata = duty_q[3];
            A_CAP0:   bus_rdata = cap_q[0];
            A_CAP1:   bus_rdata = cap_q[1];
            A_STAT:   bus_rdata = CW'({cap_flag, ovf_flag});
            A_CAPIE:  bus_rdata = CW'(cap_ie);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/arpwm_timer_chk.sv
module arpwm_timer_chk
    import arpwm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               wrap,
    input logic               cnt_wr,
    input logic [CW-1:0]      wdata,
    input logic [CW-1:0]      cnt_q,
    input logic [CW-1:0]      reload_q,
    input logic [NCH*CW-1:0]  cmp_flat,
    input logic [NCH-1:0]     pwm_o,
    input logic [NCH-1:0]     out_en,
    input logic               ovf_flag,
    input logic               ovf_ie,
    input logic               irq_ovf_o
);
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q != '1 && !cnt_wr) |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_q)); // R2
    AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == $past(reload_q)) && ovf_flag); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_ovf_o |-> (ovf_flag && ovf_ie)); // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cmp_flat)); // R4
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (pwm_o & ~out_en) == '0); // R5
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(wdata)); // R9
endmodule

bind arpwm_timer arpwm_timer_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wrap(wrap), .cnt_wr(cnt_wr),
    .wdata(bus_wdata), .cnt_q(cnt_q), .reload_q(reload_q), .cmp_flat(cmp_w),
    .pwm_o(pwm_o), .out_en(out_en), .ovf_flag(ovf_flag), .ovf_ie(ctrl_q.ovf_ie),
    .irq_ovf_o(irq_ovf_o)
);

// File: tb/arpwm_timer_tb.sv
module arpwm_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_clk_i = 1'b0;
    logic [1:0] cap_i = 2'b00;
    logic [3:0] pwm_o;
    logic       irq_ovf_o;
    logic [1:0] irq_cap_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] duty [4];

    always #5 clk = ~clk;

    arpwm_timer u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_i(ext_clk_i),
        .cap_i(cap_i), .pwm_o(pwm_o), .irq_ovf_o(irq_ovf_o), .irq_cap_o(irq_cap_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // divider sweep: interval between counter steps must be 2^s
    task automatic div_test(input int s);
        logic [7:0] c, prev;
        int t1, t2, t;
        wr(4'h0, 8'h00);
        wr(4'h1, 8'h00);
        wr(4'h2, 8'h00);
        wr(4'h0, 8'((s << 1) | 1));
        t1 = -1; t2 = -1; t = 0;
        rd(4'h2, prev);
        while (t2 < 0 && t < 700) begin
            @(negedge clk); t++;
            rd(4'h2, c);
            if (c != prev) begin
                if (t1 < 0) t1 = t; else t2 = t;
            end
            prev = c;
        end
        chk(32'(t2 - t1), 32'(1 << s), $sformatf("R2 divide s=%0d", s));
        wr(4'h0, 8'h00);
    endtask

    task automatic run_pwm(input logic [7:0] r, input logic [3:0] en,
                           input logic [3:0] pol, input bit do_shadow);
        logic [7:0] cmpm [4];
        logic [7:0] c, prev, newd, st;
        logic [3:0] exp;
        bit pend, shadow_done;
        int n;
        string tag;
        wr(4'h0, 8'h00);
        wr(4'h1, r);
        for (int i = 0; i < 4; i++) wr(4'(4 + i), duty[i]);
        wr(4'h3, {pol, en});
        wr(4'hA, 8'h01);
        wr(4'h2, 8'hFF);
        wr(4'h0, 8'h21);
        @(negedge clk);
        for (int i = 0; i < 4; i++) cmpm[i] = duty[i];
        newd = 8'(int'(r) + (256 - int'(r)) * 3 / 4);
        n = 2 * (256 - int'(r)) + 4;
        pend = 0; shadow_done = 0;
        tag = do_shadow ? "R4" : ((pol & en) != 0 ? "R6" : "R5");
        rd(4'h2, prev);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd(4'h2, c);
            if (c < prev && pend) begin cmpm[0] = newd; pend = 0; end
            for (int i = 0; i < 4; i++)
                exp[i] = en[i] & (((cmpm[i] != 8'hFF) && (c >= cmpm[i])) ^ pol[i]);
            chk(32'(pwm_o), 32'(exp), $sformatf("%s r=%0h cnt=%0h", tag, r, c));
            if (do_shadow && !shadow_done && k > 4 && c == r + 8'd2) begin
                bus_addr = 4'h4; bus_wdata = newd; bus_wr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
                rd(4'h2, c);
                pend = 1; shadow_done = 1;
            end
            prev = c;
        end
        wr(4'h0, 8'h20);
        rd(4'hA, st);
        chk(32'(st[0]), 1, "R3 overflow flag set");
        chk(32'(irq_ovf_o), 1, "R3 irq with enable");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(32'(pwm_o), 0, "R1 pwm low");
        chk(32'({irq_ovf_o, irq_cap_o}), 0, "R1 irqs low");
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk(32'(v), 0, $sformatf("R1 reg %0h", a));
        end

        // R9 counter access
        wr(4'h2, 8'hA7);
        rd(4'h2, v);
        chk(32'(v), 32'hA7, "R9 counter readback");
        idle(5);
        rd(4'h2, v);
        chk(32'(v), 32'hA7, "R2 holds when run=0");

        // R2 divider
        for (int s = 0; s < 8; s++) div_test(s);

        // R5/R6/R4 PWM sweep
        for (int ri = 0; ri < 4; ri++) begin
            r = (ri == 0) ? 0 : (ri == 1) ? 128 : (ri == 2) ? 200 : 240;
            duty[0] = 8'(r + (256 - r) / 2);
            duty[1] = 8'(r);
            duty[2] = 8'hFF;
            duty[3] = 8'(r + (256 - r) / 4 + 1);
            run_pwm(8'(r), 4'hF, 4'h0, 0);
            run_pwm(8'(r), 4'hF, 4'hA, 0);
            run_pwm(8'(r), 4'h5, 4'h3, 0);
            run_pwm(8'(r), 4'hF, 4'h0, 1);
        end

        // R3 gating and clear
        wr(4'h0, 8'h00);
        chk(32'(irq_ovf_o), 0, "R3 irq masked when disabled");
        wr(4'hA, 8'h01);
        rd(4'hA, v);
        chk(32'(v[0]), 0, "R3 flag cleared");

        // R7 external events
        wr(4'h1, 8'h10);
        wr(4'h2, 8'hFD);
        wr(4'h0, 8'h11);
        repeat (5) begin
            @(negedge clk); ext_clk_i = 1'b1;
            idle(4);
            ext_clk_i = 1'b0;
            idle(4);
        end
        idle(6);
        rd(4'h2, v);
        chk(32'(v), 32'h12, "R7 five events with reload");
        rd(4'hA, v);
        chk(32'(v[0]), 1, "R7 overflow after event count");
        wr(4'h0, 8'h00);

        // R8 captures
        wr(4'h2, 8'h5A);
        wr(4'hB, 8'h03);
        wr(4'hA, 8'h07);
        wr(4'h0, 8'h80);
        @(negedge clk); cap_i[0] = 1'b1;
        idle(6);
        rd(4'h8, v);
        chk(32'(v), 32'h5A, "R8 capture0 rising");
        rd(4'hA, v);
        chk(32'(v[1]), 1, "R8 capture0 flag");
        chk(32'(irq_cap_o[0]), 1, "R8 capture0 irq");
        cap_i[1] = 1'b1;
        idle(6);
        rd(4'hA, v);
        chk(32'(v[2]), 0, "R8 capture1 ignores rising");
        rd(4'h9, v);
        chk(32'(v), 0, "R8 capture1 unchanged on rising");
        wr(4'h2, 8'h33);
        cap_i[1] = 1'b0;
        cap_i[0] = 1'b0;
        idle(6);
        rd(4'h9, v);
        chk(32'(v), 32'h33, "R8 capture1 falling");
        chk(32'(irq_cap_o[1]), 1, "R8 capture1 irq");
        rd(4'h8, v);
        chk(32'(v), 32'h5A, "R8 capture0 ignores falling");
        wr(4'hA, 8'h06);
        chk(32'(irq_cap_o), 0, "R8 flags cleared");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule